// File: doc/BRIEF.md
# Receive FIFO Threshold and Flow-Control Unit

This block holds the control word of a serial port with transmit and receive FIFOs. It also watches the receive FIFO occupancy. Two programmable thresholds are taken from the control word and compared against the occupancy count. The first comparison drives a sticky "receive data full" status flag. The second drives a request-to-send style flow-control output, which tells the far end to stop sending.

The control word also produces several level outputs:
- FIFO clear requests for the transmit FIFO and for the receive FIFO.
- A loopback enable.
- A modem-control enable, which gates the flow-control output.
- The transmit trigger field, passed through to the transmitter.

The CPU can write the word at any time and read it back combinationally. The FIFO storage, the shifters and the loopback path sit outside this block.

Top module: `rx_fifo_flowctl`

## Requirements
- R1: After reset, the readback word is 0x0000. After reset, `data_full`, `rts_out`, `tx_fifo_rst`, `rx_fifo_rst`, `loop_en`, `mce_en` and `tx_trig` are all 0.
- R2: Bits 15..11 of the control word always read as 0, and values written to them have no effect.
- R3: Bits 10..0 of the control word read back exactly the value last written to them.
- R4: Bits 10..8 select the flow-control threshold: 000=63, 001=1, 010=8, 011=16, 100=32, 101=48, 110=54, 111=60.
- R5: `rts_out` is 1 only when `rx_count` is strictly greater than the selected flow-control threshold. It is 0 when the count equals the threshold.
- R6: When bit 3 (modem-control enable) is 0, `rts_out` is 0 whatever the occupancy.
- R7: Bits 7..6 select the receive threshold: 00=1, 01=16, 10=32, 11=48. `data_full` becomes 1 when `rx_count` is greater than or equal to that threshold.
- R8: `data_full` stays at 1 after the occupancy falls below the threshold. It returns to 0 only on a `flag_clr` strobe taken while the occupancy is below the threshold.
- R9: A `flag_clr` strobe while the occupancy is at or above the receive threshold leaves `data_full` at 1.
- R10: The control bits drive these outputs for as long as the bit holds 1:
  - bit 2 drives `tx_fifo_rst`
  - bit 1 drives `rx_fifo_rst`
  - bit 0 drives `loop_en`
  - bit 3 drives `mce_en`
  - bits 5..4 drive `tx_trig`
- R11: `rts_out` and `data_full` are registered. They reflect a change in `rx_count` or in the control word one clock after that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | Write strobe for the control word |
| cpu_wdata | input | 16 | Control word write data |
| cpu_rdata | output | 16 | Control word readback |
| rx_count | input | 7 | Receive FIFO occupancy, 0 to 64 |
| flag_clr | input | 1 | Clear strobe for the data-full flag |
| data_full | output | 1 | Sticky receive-threshold flag |
| rts_out | output | 1 | Flow-control output |
| tx_fifo_rst | output | 1 | Transmit FIFO clear request |
| rx_fifo_rst | output | 1 | Receive FIFO clear request |
| loop_en | output | 1 | Loopback enable |
| mce_en | output | 1 | Modem-control enable |
| tx_trig | output | 2 | Transmit trigger field |

## Verification
The assertions assume that `rx_count` never exceeds the FIFO depth. They also assume that `rx_count`, `flag_clr` and the write port are stable around each rising edge. The assertions relate each registered output to the occupancy and thresholds sampled one edge earlier.

The stimulus changes every input only on the falling clock edge. It keeps `rx_count` between 0 and 64. It drives the occupancy to exactly each threshold, and to one above and one below it, so that both comparisons are exercised at their edges.

// File: rtl/rxtrig_pkg.sv
package rxtrig_pkg;

   // Field layout of the stored part of the control word, bit 10 down to bit 0
   typedef struct packed {
      logic [2:0] rts_sel;   // bits 10..8
      logic [1:0] rx_sel;    // bits 7..6
      logic [1:0] tx_sel;    // bits 5..4
      logic       mce;       // bit 3
      logic       tx_clr;    // bit 2
      logic       rx_clr;    // bit 1
      logic       loop;      // bit 0
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);

   // Flow-control threshold; the code is deliberately not monotonic
   function automatic logic [7:0] rts_level(input logic [2:0] code);
      case (code)
         3'd0:    rts_level = 8'd63;
         3'd1:    rts_level = 8'd1;
         3'd2:    rts_level = 8'd8;
         3'd3:    rts_level = 8'd16;
         3'd4:    rts_level = 8'd32;
         3'd5:    rts_level = 8'd48;
         3'd6:    rts_level = 8'd54;
         default: rts_level = 8'd60;
      endcase
   endfunction

   // Receive flag threshold
   function automatic logic [7:0] rx_level(input logic [1:0] code);
      case (code)
         2'd0:    rx_level = 8'd1;
         2'd1:    rx_level = 8'd16;
         2'd2:    rx_level = 8'd32;
         default: rx_level = 8'd48;
      endcase
   endfunction

endpackage

// File: rtl/rxtrig_ctlreg.sv
module rxtrig_ctlreg
   import rxtrig_pkg::*;
#(
   parameter int REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   output ctl_t             ctl,
   output logic [REG_W-1:0] rdata
);
   localparam int PAD_W = REG_W - CTL_W;

   if (PAD_W < 1) begin : g_bad_width
      $error("rxtrig_ctlreg: REG_W must exceed the field width");
   end

   ctl_t ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ctl_q <= '0;
      else if (wr)  ctl_q <= ctl_t'(wdata[CTL_W-1:0]);
   end

   // Reserved upper bits are dropped on write
   logic unused_pad;
   assign unused_pad = ^wdata[REG_W-1:CTL_W];

   assign ctl   = ctl_q;
   assign rdata = {{PAD_W{1'b0}}, ctl_q};

   // R3: a write is visible at the readback on the next cycle
   p_write_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (rdata[CTL_W-1:0] == $past(wdata[CTL_W-1:0])));

   // R3: without a write the stored word holds
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(rdata));

endmodule

// File: rtl/rxtrig_cmp.sv
module rxtrig_cmp #(
   parameter int W      = 7,
   parameter bit STRICT = 1'b0
) (
   input  logic [W-1:0] level,
   input  logic [W-1:0] thr,
   output logic         hit
);
   if (W < 1) begin : g_bad_w
      $error("rxtrig_cmp: W must be positive");
   end

   if (STRICT) begin : g_gt
      assign hit = (level > thr);
   end else begin : g_ge
      assign hit = (level >= thr);
   end

endmodule

// File: rtl/rx_fifo_flowctl.sv
module rx_fifo_flowctl
   import rxtrig_pkg::*;
#(
   parameter int FIFO_DEPTH = 64,
   parameter int REG_W      = 16,
   localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_wr,
   input  logic [REG_W-1:0] cpu_wdata,
   output logic [REG_W-1:0] cpu_rdata,
   input  logic [CNT_W-1:0] rx_count,
   input  logic             flag_clr,
   output logic             data_full,
   output logic             rts_out,
   output logic             tx_fifo_rst,
   output logic             rx_fifo_rst,
   output logic             loop_en,
   output logic             mce_en,
   output logic [1:0]       tx_trig
);
   if (FIFO_DEPTH < 64) begin : g_bad_depth
      $error("rx_fifo_flowctl: FIFO_DEPTH must hold the largest threshold");
   end
   if (CNT_W > 8) begin : g_bad_cnt
      $error("rx_fifo_flowctl: occupancy width exceeds threshold width");
   end

   ctl_t ctl;

   rxtrig_ctlreg #(.REG_W(REG_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cpu_wr),
      .wdata (cpu_wdata),
      .ctl   (ctl),
      .rdata (cpu_rdata)
   );

   logic [7:0]       rts_full, rx_full;
   logic [CNT_W-1:0] rts_thr, rx_thr;
   logic             rts_hit, rx_hit;
   logic             unused_thr;

   assign rts_full = rts_level(ctl.rts_sel);
   assign rx_full  = rx_level(ctl.rx_sel);
   assign rts_thr  = rts_full[CNT_W-1:0];
   assign rx_thr   = rx_full[CNT_W-1:0];
   assign unused_thr = ^{rts_full, rx_full};

   rxtrig_cmp #(.W(CNT_W), .STRICT(1'b1)) u_rts_cmp (
      .level (rx_count),
      .thr   (rts_thr),
      .hit   (rts_hit)
   );

   rxtrig_cmp #(.W(CNT_W), .STRICT(1'b0)) u_rx_cmp (
      .level (rx_count),
      .thr   (rx_thr),
      .hit   (rx_hit)
   );

   logic rts_q, full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rts_q  <= 1'b0;
         full_q <= 1'b0;
      end else begin
         rts_q  <= ctl.mce & rts_hit;
         full_q <= rx_hit | (full_q & ~flag_clr);
      end
   end

   assign rts_out     = rts_q;
   assign data_full   = full_q;
   assign tx_fifo_rst = ctl.tx_clr;
   assign rx_fifo_rst = ctl.rx_clr;
   assign loop_en     = ctl.loop;
   assign mce_en      = ctl.mce;
   assign tx_trig     = ctl.tx_sel;

   // R5: at or below the threshold the flow-control output drops
   p_rts_strict_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count <= rts_thr) |=> !rts_out);

   // R6: disabled modem control forces the output low
   p_rts_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !mce_en |=> !rts_out);

   // R7: reaching the receive threshold raises the flag
   p_full_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count >= rx_thr) |=> data_full);

   // R8: the flag holds without a clear strobe
   p_full_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (data_full && !flag_clr) |=> data_full);

   // R8: a clear below the threshold drops the flag
   p_full_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && (rx_count < rx_thr)) |=> !data_full);

   // Stimulus contract: the occupancy never exceeds the depth
   p_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      rx_count <= CNT_W'(FIFO_DEPTH));

endmodule

// File: tb/rx_fifo_flowctl_tb.sv
module rx_fifo_flowctl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [15:0] cpu_wdata = '0;
   logic [15:0] cpu_rdata;
   logic [6:0]  rx_count = '0;
   logic        flag_clr = 1'b0;
   logic        data_full, rts_out, tx_fifo_rst, rx_fifo_rst, loop_en, mce_en;
   logic [1:0]  tx_trig;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   rx_fifo_flowctl u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .rx_count(rx_count), .flag_clr(flag_clr),
      .data_full(data_full), .rts_out(rts_out), .tx_fifo_rst(tx_fifo_rst),
      .rx_fifo_rst(rx_fifo_rst), .loop_en(loop_en), .mce_en(mce_en),
      .tx_trig(tx_trig)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); @(negedge clk); #1;
   endtask

   task automatic wr_reg(input logic [15:0] v);
      @(negedge clk); cpu_wr = 1'b1; cpu_wdata = v;
      @(posedge clk); @(negedge clk); cpu_wr = 1'b0; #1;
   endtask

   task automatic set_count(input int c);
      @(negedge clk); rx_count = 7'(c); #1;
   endtask

   task automatic pulse_clr();
      @(negedge clk); flag_clr = 1'b1;
      @(posedge clk); @(negedge clk); flag_clr = 1'b0; #1;
   endtask

   function automatic int rts_ref(input int code);
      case (code)
         0: return 63; 1: return 1; 2: return 8; 3: return 16;
         4: return 32; 5: return 48; 6: return 54; default: return 60;
      endcase
   endfunction

   function automatic int rx_ref(input int code);
      case (code)
         0: return 1; 1: return 16; 2: return 32; default: return 48;
      endcase
   endfunction

   task automatic t_reset();
      chk("R1 rdata", cpu_rdata, 0);
      chk("R1 outputs", {data_full, rts_out, tx_fifo_rst, rx_fifo_rst, loop_en, mce_en, tx_trig}, 0);
   endtask

   task automatic t_regs();
      wr_reg(16'hFFFF);
      chk("R2 R3 all ones", cpu_rdata, 16'h07FF);
      wr_reg(16'hF800);
      chk("R2 reserved only", cpu_rdata, 16'h0000);
      wr_reg(16'h0555);
      chk("R3 pattern", cpu_rdata, 16'h0555);
      wr_reg(16'h000F);
      chk("R10 low bits", {mce_en, tx_fifo_rst, rx_fifo_rst, loop_en, tx_trig}, 6'b111100);
      tick();
      chk("R10 level held", {tx_fifo_rst, rx_fifo_rst}, 2'b11);
      wr_reg(16'h0030);
      chk("R10 trig field", {mce_en, tx_fifo_rst, rx_fifo_rst, loop_en, tx_trig}, 6'b000011);
      wr_reg(16'h0004);
      chk("R10 tx clear only", {tx_fifo_rst, rx_fifo_rst}, 2'b10);
   endtask

   task automatic t_rts();
      for (int c = 0; c < 8; c++) begin
         set_count(0);
         wr_reg(16'((c << 8) | 8));
         set_count(rts_ref(c));
         tick();
         chk($sformatf("R4 R5 code %0d at threshold", c), rts_out, 0);
         set_count(rts_ref(c) + 1);
         tick();
         chk($sformatf("R4 R5 code %0d above threshold", c), rts_out, 1);
      end
      set_count(0);
      tick();
   endtask

   task automatic t_mce();
      wr_reg(16'h0100);
      set_count(10);
      tick();
      chk("R6 gated off", rts_out, 0);
      wr_reg(16'h0108);
      chk("R11 rts one cycle late", rts_out, 0);
      tick();
      chk("R6 R11 enabled", rts_out, 1);
      set_count(0);
      tick();
   endtask

   task automatic t_rxtrig();
      for (int s = 0; s < 4; s++) begin
         set_count(0);
         wr_reg(16'(s << 6));
         pulse_clr();
         chk($sformatf("R8 cleared code %0d", s), data_full, 0);
         set_count(rx_ref(s) - 1);
         tick();
         chk($sformatf("R7 code %0d below", s), data_full, 0);
         set_count(rx_ref(s));
         tick();
         chk($sformatf("R7 code %0d at threshold", s), data_full, 1);
      end
   endtask

   task automatic t_sticky();
      set_count(0);
      wr_reg(16'h0040);
      pulse_clr();
      set_count(20);
      chk("R11 flag one cycle late", data_full, 0);
      tick();
      chk("R7 set", data_full, 1);
      set_count(5);
      tick();
      chk("R8 sticky", data_full, 1);
      set_count(20);
      pulse_clr();
      chk("R9 clear ignored", data_full, 1);
      set_count(5);
      tick();
      pulse_clr();
      chk("R8 clear below", data_full, 0);
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      t_regs();
      t_rts();
      t_mce();
      t_rxtrig();
      t_sticky();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule